// File: doc/BRIEF.md
# Static Branch Fetch Steering Controller

This controller sits beside the fetch stage of a five-stage in-order pipeline and chooses the address fetched in the next cycle. Conditional branches are seen in decode and resolved one stage later in execute. The controller follows one of four runtime-selected handling modes: freeze until resolved, assume fall-through, assume taken, or delayed branch with one to three always-executed slots. For each mode it drives its own sequence of fetch-hold, redirect and squash signals. Unconditional jumps are detected by a predecoder at fetch and folded away: the jump word never enters decode, and fetch goes straight to its target.

The environment contract is as follows. Execute reports the outcome in the cycle after the branch was decoded. Only the freeze mode tolerates a later report. No further branch is decoded while one is being handled. The fetch PC register lives outside the block and loads `next_pc` every cycle. For each mode, a counter accumulates the pipeline slots lost to holds and squashes, so the cost of each mode can be compared.

Top module: `fetch_steer`

## Requirements
- R1: After reset, `flush` is 0, `stall_fd` is 0, `fetch_kill` is 0, every bubble counter field is 0, and with no event `next_pc` equals `fetch_pc + 4`.
- R2: With no branch activity, `next_pc` is `fetch_pc + 4`. When `pd_jump` is high, the jump is folded: `next_pc` equals `pd_target` and `fetch_kill` is 1. Folding adds nothing to any bubble counter.
- R3: Mode code 0 (freeze): from the decode cycle until the cycle `ex_valid` arrives, `stall_fd` is 1 and `next_pc` equals `fetch_pc`. In the resolve cycle, a not-taken outcome gives `fetch_pc + 4` with no flush. A taken outcome gives `ex_target` with `flush = 2'b01`.
- R4: Mode code 1 (assume fall-through): the decode cycle fetches sequentially. A taken outcome redirects to `ex_target` with `flush = 2'b11`. A not-taken outcome changes nothing.
- R5: Mode code 2 (assume taken): the decode cycle redirects to `dec_target` with `flush = 2'b01`. A taken outcome then continues sequentially. A not-taken outcome returns to the address that was being fetched in the decode cycle, with `flush = 2'b01`.
- R6: Mode code 3 (delayed): `slot_cnt` gives N slots, and a value of 0 counts as 1. The N instructions after the branch are fetched sequentially and are never squashed. When the branch is taken with N=1, the resolve cycle redirects to `ex_target` with `flush = 2'b01`. When N is 2 or more, fetch goes to the target in the cycle that fetches the last slot, with no flush.
- R7: `flush` bit 0 squashes the fetch stage and bit 1 squashes the decode stage. Bit 1 is set only in a taken resolve under mode 1. No flush is raised together with `stall_fd`.
- R8: `bubble_cnt` bits [k*CW +: CW] hold the counter for mode code k. Each cycle, this counter grows by `stall_fd` plus the number of set `flush` bits, charged to the mode that handled the branch.
- R9: `policy_sel` and `slot_cnt` are taken up only in a cycle with no branch in flight and none in decode, and take effect from the next cycle. A change made while a branch is being handled does not alter how that branch is handled.
- R10: A resolve redirect and a decode redirect take priority over folding. In such a cycle `fetch_kill` is 0 and `next_pc` is the redirect address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Requested handling mode (0 freeze, 1 fall-through, 2 taken, 3 delayed) |
| slot_cnt | input | 2 | Delay slots for mode 3 (0 treated as 1) |
| fetch_pc | input | AW | Address fetched this cycle |
| pd_jump | input | 1 | Predecoder sees an unconditional jump at `fetch_pc` |
| pd_target | input | AW | Target of that jump |
| dec_branch | input | 1 | Conditional branch in decode |
| dec_target | input | AW | Target computed in decode |
| ex_valid | input | 1 | Execute reports a branch outcome |
| ex_taken | input | 1 | Outcome is taken |
| ex_target | input | AW | Target resolved in execute |
| next_pc | output | AW | Address to fetch next cycle |
| stall_fd | output | 1 | Hold fetch and decode |
| flush | output | 2 | Squash: bit 0 fetch stage, bit 1 decode stage |
| fetch_kill | output | 1 | Drop the folded jump word at fetch |
| bubble_cnt | output | 4*CW | Lost-slot counters, one field per mode |

## Verification
Jump folding at fetch can fall in the same cycle as a redirect caused by branch resolution. Mode changes can also arrive while a branch is being handled. The bench raises `pd_jump` in the resolve cycle of a taken branch. It then expects the resolved target, a full squash and no kill. It also writes a new mode in the decode cycle of a branch, and expects the old mode's sequence and counter charge to complete. Random runs mix modes, slot counts, outcomes, targets and folded jumps, and compare every cycle against bench-computed addresses and penalties.

// File: rtl/fetch_steer.sv
module fetch_steer #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int INC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy_sel,
  input  logic [1:0]        slot_cnt,
  input  logic [AW-1:0]     fetch_pc,
  input  logic              pd_jump,
  input  logic [AW-1:0]     pd_target,
  input  logic              dec_branch,
  input  logic [AW-1:0]     dec_target,
  input  logic              ex_valid,
  input  logic              ex_taken,
  input  logic [AW-1:0]     ex_target,
  output logic [AW-1:0]     next_pc,
  output logic              stall_fd,
  output logic [1:0]        flush,
  output logic              fetch_kill,
  output logic [4*CW-1:0]   bubble_cnt
);
  localparam int NPOL = 4;
  localparam logic [1:0] M_FRZ = 2'd0, M_FT = 2'd1, M_TK = 2'd2, M_DLY = 2'd3;

  logic [1:0]    pol_q, nds_q, rem_q;
  logic          infl_q, pend_q;
  logic [AW-1:0] ft_q, pend_tgt_q;
  logic [CW-1:0] cnt_q [NPOL];
  logic [AW-1:0] seq_pc;
  logic          busy, acc, res, ovr;
  logic [CW-1:0] inc;

  assign seq_pc = fetch_pc + AW'(INC);
  assign busy   = infl_q | (rem_q != 2'd0);
  assign acc    = dec_branch & ~busy;
  assign res    = ex_valid & infl_q;
  assign inc    = CW'(stall_fd) + CW'(flush[0]) + CW'(flush[1]);

  always_comb begin
    next_pc  = pd_jump ? pd_target : seq_pc;
    ovr      = 1'b0;
    flush    = 2'b00;
    stall_fd = (pol_q == M_FRZ) && (acc || (infl_q && !ex_valid));
    if (acc && pol_q == M_TK) begin
      next_pc = dec_target;
      flush   = 2'b01;
      ovr     = 1'b1;
    end
    if (pend_q && rem_q == 2'd1) begin
      next_pc = pend_tgt_q;
      ovr     = 1'b1;
    end
    if (res) begin
      case (pol_q)
        M_FRZ: if (ex_taken) begin
          next_pc = ex_target; flush = 2'b01; ovr = 1'b1;
        end
        M_FT: if (ex_taken) begin
          next_pc = ex_target; flush = 2'b11; ovr = 1'b1;
        end
        M_TK: if (!ex_taken) begin
          next_pc = ft_q; flush = 2'b01; ovr = 1'b1;
        end
        default: if (ex_taken && rem_q <= 2'd1) begin
          next_pc = ex_target;
          flush   = (rem_q == 2'd0) ? 2'b01 : 2'b00;
          ovr     = 1'b1;
        end
      endcase
    end
    if (stall_fd) next_pc = fetch_pc;
    fetch_kill = pd_jump & ~ovr & ~stall_fd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q      <= M_FRZ;
      nds_q      <= 2'd1;
      rem_q      <= 2'd0;
      infl_q     <= 1'b0;
      pend_q     <= 1'b0;
      ft_q       <= '0;
      pend_tgt_q <= '0;
      for (int k = 0; k < NPOL; k++) cnt_q[k] <= '0;
    end else begin
      if (!busy && !dec_branch) begin
        pol_q <= policy_sel;
        nds_q <= (slot_cnt == 2'd0) ? 2'd1 : slot_cnt;
      end
      if (acc) begin
        infl_q <= 1'b1;
        ft_q   <= fetch_pc;
        if (pol_q == M_DLY) rem_q <= nds_q - 2'd1;
      end else if (rem_q != 2'd0) begin
        rem_q <= rem_q - 2'd1;
      end
      if (res) begin
        infl_q <= 1'b0;
        if (pol_q == M_DLY && ex_taken && rem_q == 2'd2) begin
          pend_q     <= 1'b1;
          pend_tgt_q <= ex_target;
        end
      end
      if (pend_q && rem_q == 2'd1) pend_q <= 1'b0;
      if (inc != '0) cnt_q[pol_q] <= cnt_q[pol_q] + inc;
    end
  end

  for (genvar g = 0; g < NPOL; g++) begin : g_cnt
    assign bubble_cnt[g*CW +: CW] = cnt_q[g];
  end
endmodule

// File: rtl/fetch_steer_chk.sv
module fetch_steer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_fd,
  input logic [1:0]    flush,
  input logic          fetch_kill,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] fetch_pc,
  input logic          pd_jump,
  input logic [AW-1:0] pd_target,
  input logic          ex_valid,
  input logic          ex_taken,
  input logic          infl_q,
  input logic [1:0]    pol_q
);
  AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> next_pc == fetch_pc); // R3
  AST_RESOLVE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && infl_q) |-> !stall_fd); // R3
  AST_DEEP_SQUASH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |-> (ex_valid && ex_taken)); // R7
  AST_NO_SQUASH_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> flush == 2'b00); // R7
  AST_FOLD_GOES_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kill |-> (pd_jump && next_pc == pd_target)); // R2
  AST_FOLD_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kill |-> (flush == 2'b00 && !stall_fd)); // R10
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    infl_q |=> $stable(pol_q)); // R9
endmodule

bind fetch_steer fetch_steer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_fd(stall_fd), .flush(flush),
  .fetch_kill(fetch_kill), .next_pc(next_pc), .fetch_pc(fetch_pc),
  .pd_jump(pd_jump), .pd_target(pd_target), .ex_valid(ex_valid),
  .ex_taken(ex_taken), .infl_q(infl_q), .pol_q(pol_q)
);

// File: tb/sim_fetch_steer.sv
module sim_fetch_steer;
  localparam int AW = 32, CW = 16, INC = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [1:0] policy_sel, slot_cnt, flush;
  logic [AW-1:0] fpc, pd_target, dec_target, ex_target, next_pc;
  logic pd_jump, dec_branch, ex_valid, ex_taken, stall_fd, fetch_kill;
  logic [4*CW-1:0] bubble_cnt;
  int checks = 0, fails = 0;
  int exp_cnt [4];
  bit done = 0;

  fetch_steer #(.AW(AW), .CW(CW), .INC(INC)) u0 (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .slot_cnt(slot_cnt),
    .fetch_pc(fpc), .pd_jump(pd_jump), .pd_target(pd_target),
    .dec_branch(dec_branch), .dec_target(dec_target), .ex_valid(ex_valid),
    .ex_taken(ex_taken), .ex_target(ex_target), .next_pc(next_pc),
    .stall_fd(stall_fd), .flush(flush), .fetch_kill(fetch_kill),
    .bubble_cnt(bubble_cnt));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) fpc <= 32'h0000_1000; else fpc <= next_pc;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    pd_jump = 0; dec_branch = 0; ex_valid = 0; ex_taken = 0;
  endtask

  task automatic chk_cnt();
    for (int k = 0; k < 4; k++)
      chk("R8 bubble counter", 64'(bubble_cnt[k*CW +: CW]), 64'(exp_cnt[k]));
  endtask

  function automatic int penalty(int pol, int ns, bit tk);
    case (pol)
      0: return tk ? 2 : 1;
      1: return tk ? 2 : 0;
      2: return tk ? 1 : 2;
      default: return (tk && ns == 1) ? 1 : 0;
    endcase
  endfunction

  task automatic run_branch(int pol, int nsraw, bit tk, logic [AW-1:0] tgt);
    int ns;
    logic [AW-1:0] f, p1;
    ns = (nsraw == 0) ? 1 : nsraw;
    @(negedge clk); clr(); policy_sel = 2'(pol); slot_cnt = 2'(nsraw);
    @(negedge clk); #1;
    chk("R2 idle next", 64'(next_pc), 64'(fpc + INC));
    chk("R2 idle quiet", {flush, stall_fd}, 3'b000);
    @(negedge clk); dec_branch = 1; dec_target = tgt; #1;
    f = fpc;
    case (pol)
      0: begin chk("R3 hold", {stall_fd, flush}, 3'b100); chk("R3 pc", 64'(next_pc), 64'(f)); end
      1: begin chk("R4 decode", {stall_fd, flush}, 3'b000); chk("R4 pc", 64'(next_pc), 64'(f + INC)); end
      2: begin chk("R5 decode", {stall_fd, flush}, 3'b001); chk("R5 pc", 64'(next_pc), 64'(tgt)); end
      default: begin chk("R6 decode", {stall_fd, flush}, 3'b000); chk("R6 pc", 64'(next_pc), 64'(f + INC)); end
    endcase
    @(negedge clk); dec_branch = 0; ex_valid = 1; ex_taken = tk; ex_target = tgt; #1;
    p1 = fpc;
    case (pol)
      0: begin
        chk("R3 resolve pc", 64'(next_pc), 64'(tk ? tgt : f + INC));
        chk("R3 resolve flush", {stall_fd, flush}, tk ? 3'b001 : 3'b000);
      end
      1: begin
        chk("R4 resolve pc", 64'(next_pc), 64'(tk ? tgt : p1 + INC));
        chk("R7 resolve flush", {stall_fd, flush}, tk ? 3'b011 : 3'b000);
      end
      2: begin
        chk("R5 resolve pc", 64'(next_pc), 64'(tk ? p1 + INC : f));
        chk("R5 resolve flush", {stall_fd, flush}, tk ? 3'b000 : 3'b001);
      end
      default: begin
        chk("R6 resolve pc", 64'(next_pc), 64'((tk && ns < 3) ? tgt : p1 + INC));
        chk("R6 resolve flush", {stall_fd, flush}, (tk && ns == 1) ? 3'b001 : 3'b000);
      end
    endcase
    if (pol == 3 && ns == 3) begin
      @(negedge clk); clr(); #1;
      chk("R6 last slot pc", 64'(next_pc), 64'(tk ? tgt : fpc + INC));
      chk("R6 slot no flush", {stall_fd, flush}, 3'b000);
    end
    exp_cnt[pol] += penalty(pol, ns, tk);
    @(negedge clk); clr();
    @(negedge clk); #1;
    chk_cnt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] t;
    for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
    clr(); policy_sel = 0; slot_cnt = 0;
    pd_target = 0; dec_target = 0; ex_target = 0;
    rst_n = 0;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 reset quiet", {fetch_kill, stall_fd, flush}, 4'b0000);
    chk("R1 reset next", 64'(next_pc), 64'(fpc + INC));
    chk_cnt();

    // R2 folding of an unconditional jump
    @(negedge clk); pd_jump = 1; pd_target = 32'h0000_4440; #1;
    chk("R2 fold pc", 64'(next_pc), 64'h4440);
    chk("R2 fold kill", {fetch_kill, flush, stall_fd}, 4'b1000);
    @(negedge clk); clr(); @(negedge clk); #1; chk_cnt();

    // directed sweep of every mode, slot count and outcome
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int tk = 0; tk < 2; tk++)
          run_branch(p, s, tk[0], 32'h0000_8000 + 32'(p * 256 + s * 16 + tk * 4));

    // R3 late resolution keeps the hold
    @(negedge clk); clr(); policy_sel = 0;
    @(negedge clk); dec_branch = 1; dec_target = 32'h9000; #1;
    chk("R3 late hold c0", {stall_fd, flush}, 3'b100);
    @(negedge clk); clr(); #1;
    chk("R3 late hold c1", {stall_fd, flush}, 3'b100);
    chk("R3 late pc", 64'(next_pc), 64'(fpc));
    @(negedge clk); ex_valid = 1; ex_taken = 0; #1;
    chk("R3 late release", {stall_fd, flush}, 3'b000);
    chk("R3 late pc seq", 64'(next_pc), 64'(fpc + INC));
    exp_cnt[0] += 2;
    @(negedge clk); clr(); @(negedge clk); #1; chk_cnt();

    // R9 mode write during a branch is deferred
    @(negedge clk); clr(); policy_sel = 1;
    @(negedge clk); dec_branch = 1; dec_target = 32'hA000; policy_sel = 2; #1;
    chk("R9 old mode at decode", {stall_fd, flush}, 3'b000);
    @(negedge clk); dec_branch = 0; ex_valid = 1; ex_taken = 1; ex_target = 32'hA000; #1;
    chk("R9 old mode resolve", {stall_fd, flush}, 3'b011);
    chk("R9 old mode pc", 64'(next_pc), 64'hA000);
    exp_cnt[1] += 2;
    @(negedge clk); clr(); @(negedge clk); #1; chk_cnt();

    // R10 fold collides with a taken resolve
    @(negedge clk); clr(); policy_sel = 1;
    @(negedge clk); dec_branch = 1; dec_target = 32'hB000;
    @(negedge clk); dec_branch = 0; ex_valid = 1; ex_taken = 1; ex_target = 32'hB000;
    pd_jump = 1; pd_target = 32'hC000; #1;
    chk("R10 redirect wins pc", 64'(next_pc), 64'hB000);
    chk("R10 no kill", {fetch_kill, flush}, 3'b011);
    exp_cnt[1] += 2;
    @(negedge clk); clr(); @(negedge clk); #1; chk_cnt();

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      t = $urandom & ~32'h3;
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk); clr(); pd_jump = 1; pd_target = t; #1;
        chk("R2 random fold", 64'(next_pc), 64'(t));
        chk("R2 random kill", 64'(fetch_kill), 64'd1);
        @(negedge clk); clr();
      end else begin
        run_branch(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), t);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule